// File: doc/BRIEF.md
# Serial-Bus Slave Engine for an 8K x 8 Nonvolatile Memory

This block is the two-wire serial-bus slave front end of a byte-wide nonvolatile memory of 8192 locations. The block samples the bus clock and data lines with the system clock. It recognises the start and stop framing conditions, shifts bytes in, and shifts bytes out. It then decides, byte by byte, whether to acknowledge.

The first byte of every command is a control byte. It holds a fixed four-bit device code, three chip-select bits and a direction bit. Only a control byte whose select bits equal the three strap inputs is answered, so up to eight devices can share one bus. A write command is followed by two address bytes and then data bytes. The data bytes go to a separate write-cache block, one strobe per byte. A read command streams bytes out of a synchronous memory port, starting at the current address pointer.

Whenever the companion programming logic reports that a self-timed programming cycle is in progress, the block acknowledges nothing. A bus master can therefore poll with control bytes until it gets an acknowledge.

Top module: `eebus_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START. A START in any state, including in the middle of a byte, clears the bit count and begins reception of a new control byte.
- R2: A rising SDA while SCL is high is a STOP. After a STOP or reset, the block drives nothing, and bytes clocked without a new START are neither acknowledged nor forwarded.
- R3: Bits are taken on SCL rising edges, most significant bit first. The control byte is bits 7..4 = 4'b1010, bits 3..1 = select, and bit 0 = direction (1 = read). It is acknowledged only when the code matches and the select equals `sel_pins`.
- R4: An acknowledge pulls SDA low from shortly after the eighth SCL falling edge until shortly after the ninth, so it covers the whole high time of the ninth pulse. SDA is then released.
- R5: While `prog_busy` is high when a byte completes, that byte (control, address or data) is not acknowledged and no write strobe is issued.
- R6: A write command takes the high address byte, then the low address byte. Bits 7..5 of the high byte are ignored, which gives a 13-bit address.
- R7: Each acknowledged write data byte produces a one-cycle `wr_valid` carrying the byte and the current address. The address then increments, and it wraps from 0x1FFF to 0x0000.
- R8: A read fetches `mem_rd_data` one clock after `mem_rd_en`, using `mem_addr`. It sends the byte MSB first, each bit changed only while SCL is low. The address increments after every fetch and wraps from 0x1FFF to 0x0000.
- R9: A read control byte starts at the current pointer. That pointer is either the value left by the last access, or the address just written by a write command that was cut short by a repeated START.
- R10: A master acknowledge (SDA low on the ninth pulse) continues the read. A master no-acknowledge ends it, and the slave keeps SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (wired level) |
| sda_drive_low | output | 1 | 1 pulls the open-drain data line low |
| sel_pins | input | 3 | Strapped chip-select value |
| prog_busy | input | 1 | Programming cycle in progress |
| mem_rd_en | output | 1 | Read strobe to the memory port |
| mem_addr | output | 13 | Read address |
| mem_rd_data | input | 8 | Read data, valid one clock after the strobe |
| wr_valid | output | 1 | One-cycle strobe of a write data byte |
| wr_addr | output | 13 | Address of the forwarded byte |
| wr_data | output | 8 | Forwarded byte |

## Verification
The case that needs care is when `prog_busy` rises at the very moment a data byte completes. The acknowledge decision is still pending behind the input synchroniser at that point, so the busy report and the decision land together. The bench raises `prog_busy` in the same clock in which it drops SCL after the eighth data bit. It then expects no acknowledge in the ninth pulse and no write strobe. A control-byte poll is then acknowledged once the busy input falls.

// File: rtl/eebus_pkg.sv
// Package: shared types and fixed protocol constants of the serial-bus slave.
// Assumes the byte format is fixed at eight bits: device code, select, direction.
package eebus_pkg;
    localparam int          SEL_W    = 3;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a START
        ST_CTRL,   // receiving the control byte
        ST_AHI,    // receiving the high address byte
        ST_ALO,    // receiving the low address byte
        ST_WDAT,   // receiving write data
        ST_ACK,    // holding an acknowledge through the ninth pulse
        ST_RDAT,   // sending a read byte
        ST_RACK    // sampling the master's acknowledge
    } eeb_state_t;
endpackage

// File: rtl/eebus_line_cond.sv
// Line conditioner: brings SCL and SDA into the clock domain and flags
// SCL edges and START/STOP framing conditions, one clock wide each.
// Assumes clk runs at least several times faster than SCL.
module eebus_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_c;

    assign scl_c   = scl_sh[STAGES-1];
    assign sda_lvl = sda_sh[STAGES-1];

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_c;
            sda_p  <= sda_lvl;
        end
    end

    // Edge and framing decode from the current and previous samples.
    always_comb begin
        scl_rise  = scl_c & ~scl_p;
        scl_fall  = ~scl_c & scl_p;
        start_det = scl_c & scl_p & sda_p & ~sda_lvl;
        stop_det  = scl_c & scl_p & ~sda_p & sda_lvl;
    end
endmodule

// File: rtl/eebus_addr_ptr.sv
// Address pointer: loads a full address or advances by one, wrapping at
// the top of the array. Assumes load and step are never needed together.
module eebus_addr_ptr #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    // Pointer register: load has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (step)
            ptr <= ptr + 1'b1;
    end

    // The last location is followed by location zero (R7, R8).
    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && ptr == {ADDR_W{1'b1}}) |=> (ptr == '0));
endmodule

// File: rtl/eebus_slave.sv
// Serial-bus slave engine: frames commands, decodes the control byte,
// builds the byte address, acknowledges, forwards write bytes and streams
// read bytes. Assumes a memory port with exactly one clock read latency and
// a prog_busy input synchronous to clk.
module eebus_slave
    import eebus_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic [SEL_W-1:0]  sel_pins,
    input  logic              prog_busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int HI_W = ADDR_W - 8;

    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    eeb_state_t        state, nxt_q, byte_next;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [HI_W-1:0]   addr_hi;
    logic              ack_oe, data_oe, rack_ok;
    logic              rd_en_q, rd_pend, wr_valid_q;
    logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
    logic [7:0]        wr_data_q;
    logic [ADDR_W-1:0] ptr;
    logic              rx_state, byte_done, byte_ok;
    logic              ptr_load, ptr_step, issue_rd, issue_wr;

    eebus_line_cond #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eebus_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val({addr_hi, shreg}), .step(ptr_step), .ptr(ptr)
    );

    assign rx_state  = (state == ST_CTRL) || (state == ST_AHI) ||
                       (state == ST_ALO)  || (state == ST_WDAT);
    assign byte_done = rx_state && scl_fall && (bit_cnt == 4'd8) &&
                       !start_det && !stop_det;

    // Per-byte decision: acknowledge, next phase, pointer and port actions.
    always_comb begin
        byte_ok   = 1'b0;
        byte_next = ST_IDLE;
        ptr_load  = 1'b0;
        issue_rd  = 1'b0;
        issue_wr  = 1'b0;
        if (byte_done && !prog_busy) begin
            case (state)
                ST_CTRL: if (shreg[7:4] == DEV_CODE && shreg[SEL_W:1] == sel_pins) begin
                    byte_ok = 1'b1;
                    if (shreg[0]) begin
                        byte_next = ST_RDAT;
                        issue_rd  = 1'b1;
                    end else begin
                        byte_next = ST_AHI;
                    end
                end
                ST_AHI: begin
                    byte_ok   = 1'b1;
                    byte_next = ST_ALO;
                end
                ST_ALO: begin
                    byte_ok   = 1'b1;
                    byte_next = ST_WDAT;
                    ptr_load  = 1'b1;
                end
                ST_WDAT: begin
                    byte_ok   = 1'b1;
                    byte_next = ST_WDAT;
                    issue_wr  = 1'b1;
                end
                default: byte_ok = 1'b0;
            endcase
        end
        if (state == ST_RACK && scl_rise && !sda_lvl && !start_det && !stop_det)
            issue_rd = 1'b1;
        ptr_step = issue_rd | issue_wr;
    end

    // Port registers: read strobe and address, read return, write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en_q    <= 1'b0;
            rd_pend    <= 1'b0;
            rd_addr_q  <= '0;
            wr_valid_q <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            rd_en_q    <= issue_rd;
            rd_pend    <= rd_en_q;
            wr_valid_q <= issue_wr;
            if (issue_rd) rd_addr_q <= ptr;
            if (issue_wr) begin
                wr_addr_q <= ptr;
                wr_data_q <= shreg;
            end
        end
    end

    // Protocol sequencer: framing, bit shifting and SDA drive control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nxt_q   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            addr_hi <= '0;
            ack_oe  <= 1'b0;
            data_oe <= 1'b0;
            rack_ok <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            ack_oe  <= 1'b0;
            data_oe <= 1'b0;
        end else if (start_det) begin
            state   <= ST_CTRL;
            bit_cnt <= '0;
            ack_oe  <= 1'b0;
            data_oe <= 1'b0;
        end else begin
            if (rd_pend) shreg <= mem_rd_data;
            case (state)
                ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_AHI) addr_hi <= shreg[HI_W-1:0];
                        if (byte_ok) begin
                            ack_oe <= 1'b1;
                            nxt_q  <= byte_next;
                            state  <= ST_ACK;
                        end else begin
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: if (scl_fall) begin
                    ack_oe <= 1'b0;
                    state  <= nxt_q;
                    if (nxt_q == ST_RDAT) begin
                        data_oe <= ~shreg[7];
                        bit_cnt <= '0;
                    end
                end
                ST_RDAT: if (scl_fall) begin
                    if (bit_cnt == 4'd7) begin
                        data_oe <= 1'b0;
                        rack_ok <= 1'b0;
                        state   <= ST_RACK;
                    end else begin
                        data_oe <= ~shreg[6];
                        shreg   <= {shreg[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (!sda_lvl) rack_ok <= 1'b1;
                        else          state   <= ST_IDLE;
                    end else if (scl_fall && rack_ok) begin
                        data_oe <= ~shreg[7];
                        bit_cnt <= '0;
                        state   <= ST_RDAT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_drive_low = ack_oe | data_oe;
    assign mem_rd_en     = rd_en_q;
    assign mem_addr      = rd_addr_q;
    assign wr_valid      = wr_valid_q;
    assign wr_addr       = wr_addr_q;
    assign wr_data       = wr_data_q;

    // A START always restarts control-byte reception (R1).
    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_CTRL && bit_cnt == 4'd0));

    // A STOP leaves the block idle with SDA released (R2).
    assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_drive_low));

    // The acknowledge ends at the falling edge of the ninth pulse (R4).
    assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && scl_fall && !start_det && !stop_det) |=> !ack_oe);

    // No acknowledge starts while programming is reported (R5).
    assert_no_ack_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_oe) |-> !$past(prog_busy));

    // No write byte is forwarded while programming is reported (R5).
    assert_no_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$past(prog_busy));

    // Read data is driven only while a read byte is being sent (R8).
    assert_data_drive_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (state == ST_RDAT));
endmodule

// File: tb/eebus_slave_tb.sv
// Directed bench: a bus master model, a computed memory and a write log.
module eebus_slave_tb;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy = 1'b0;
    logic        drv;
    logic        mem_rd_en;
    logic [12:0] mem_addr;
    logic [7:0]  mem_q = 8'h00;
    logic        wr_valid;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        bus_sda;
    int          n_chk = 0;
    int          n_err = 0;
    int          wr_cnt = 0;
    logic [12:0] wa_log [0:7];
    logic [7:0]  wd_log [0:7];

    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] CW  = 8'hAA;   // 1010 101 0
    localparam logic [7:0] CR  = 8'hAB;   // 1010 101 1

    always #4 clk = ~clk;
    assign bus_sda = sda_m & ~drv;

    eebus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(bus_sda),
        .sda_drive_low(drv), .sel_pins(SEL), .prog_busy(busy),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_q),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] mdat(input logic [12:0] a);
        return a[7:0] ^ {3'b101, a[12:8]};
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_q <= mdat(mem_addr);
        if (wr_valid) begin
            wa_log[wr_cnt % 8] <= wr_addr;
            wd_log[wr_cnt % 8] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic w(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; w(H);
            scl_m = 1'b1; w(H);
        end
        sda_m = 1'b0; w(H);
        scl_m = 1'b0; w(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(H);
        scl_m = 1'b1; w(H);
        sda_m = 1'b1; w(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; w(H);
        scl_m = 1'b1; w(H);
        scl_m = 1'b0; w(2);
    endtask

    task automatic write_byte(input logic [7:0] b, input logic busy_at_end, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; w(H);
            scl_m = 1'b1; w(H);
            scl_m = 1'b0;
            if (i == 0 && busy_at_end) busy = 1'b1;
            w(2);
        end
        sda_m = 1'b1; w(H);
        scl_m = 1'b1; w(H/2);
        acked = ~bus_sda; w(H/2);
        acked = acked & ~bus_sda;
        scl_m = 1'b0; w(2);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(H);
            scl_m = 1'b1; w(H/2);
            b[i] = bus_sda; w(H/2);
            scl_m = 1'b0; w(2);
        end
        sda_m = ~mack; w(H);
        scl_m = 1'b1; w(H);
        scl_m = 1'b0; w(2);
        sda_m = 1'b1;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
        logic a;
        bus_start();
        write_byte(CW, 1'b0, a); chk("R3 control write ack", a, 1);
        write_byte(hi, 1'b0, a); chk("R6 high address ack", a, 1);
        write_byte(lo, 1'b0, a); chk("R6 low address ack", a, 1);
    endtask

    task automatic t_reset();
        chk("R2 reset sda released", drv, 0);
        chk("R2 reset no read strobe", mem_rd_en, 0);
        chk("R2 reset no write strobe", wr_valid, 0);
    endtask

    task automatic t_select();
        logic a;
        bus_start(); write_byte(8'hA6, 1'b0, a); chk("R3 wrong select nack", a, 0); bus_stop();
        bus_start(); write_byte(8'hBA, 1'b0, a); chk("R3 wrong code nack", a, 0); bus_stop();
        bus_start(); write_byte(CW, 1'b0, a);    chk("R3 matching control ack", a, 1);
        w(6); chk("R4 ack released after ninth pulse", drv, 0);
        bus_stop();
    endtask

    task automatic t_write();
        logic a;
        int base = wr_cnt;
        set_addr(8'hF2, 8'h34);
        write_byte(8'h5A, 1'b0, a); chk("R7 data ack", a, 1);
        write_byte(8'hC3, 1'b0, a); chk("R7 data ack", a, 1);
        bus_stop();
        chk("R7 write count", wr_cnt - base, 2);
        chk("R6 upper bits ignored addr", wa_log[base % 8], 13'h1234);
        chk("R7 first data", wd_log[base % 8], 8'h5A);
        chk("R7 increment addr", wa_log[(base + 1) % 8], 13'h1235);
        chk("R7 second data", wd_log[(base + 1) % 8], 8'hC3);
    endtask

    task automatic t_write_wrap();
        logic a;
        int base = wr_cnt;
        set_addr(8'h1F, 8'hFF);
        write_byte(8'h11, 1'b0, a);
        write_byte(8'h22, 1'b0, a);
        bus_stop();
        chk("R7 wrap top addr", wa_log[base % 8], 13'h1FFF);
        chk("R7 wrap to zero", wa_log[(base + 1) % 8], 13'h0000);
    endtask

    task automatic t_rand_read();
        logic a;
        logic [7:0] d;
        int base = wr_cnt;
        set_addr(8'h0A, 8'h10);
        bus_start();
        write_byte(CR, 1'b0, a); chk("R9 read control ack after repeated start", a, 1);
        for (int i = 0; i < 3; i++) begin
            read_byte(i != 2, d);
            chk("R8 random read data", d, mdat(13'h0A10 + 13'(i)));
        end
        bus_stop();
        chk("R9 no write from address-only command", wr_cnt - base, 0);
    endtask

    task automatic t_cur_read();
        logic a;
        logic [7:0] d;
        bus_start();
        write_byte(CR, 1'b0, a);
        read_byte(1'b0, d);
        chk("R9 current address read", d, mdat(13'h0A13));
        w(4); chk("R10 sda released after master nack", drv, 0);
        scl_m = 1'b1; w(H/2);
        chk("R10 line high on extra pulse", bus_sda, 1);
        w(H/2); scl_m = 1'b0; w(H);
        bus_stop();
    endtask

    task automatic t_read_wrap();
        logic a;
        logic [7:0] d;
        set_addr(8'h1F, 8'hFE);
        bus_start();
        write_byte(CR, 1'b0, a);
        read_byte(1'b1, d); chk("R8 read at 0x1FFE", d, mdat(13'h1FFE));
        read_byte(1'b1, d); chk("R8 read at 0x1FFF", d, mdat(13'h1FFF));
        read_byte(1'b0, d); chk("R8 read wraps to 0", d, mdat(13'h0000));
        bus_stop();
    endtask

    task automatic t_busy();
        logic a;
        int base = wr_cnt;
        busy = 1'b1;
        bus_start(); write_byte(CW, 1'b0, a); chk("R5 control nack while busy", a, 0); bus_stop();
        busy = 1'b0;
        set_addr(8'h00, 8'h40);
        write_byte(8'h99, 1'b1, a);
        chk("R5 data nack when busy meets byte end", a, 0);
        busy = 1'b0;
        bus_stop();
        chk("R5 no write while busy", wr_cnt - base, 0);
        bus_start(); write_byte(CW, 1'b0, a); chk("R5 poll acked after busy", a, 1); bus_stop();
    endtask

    task automatic t_abort();
        logic a;
        int base = wr_cnt;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        write_byte(CW, 1'b0, a); chk("R1 control ack after mid-byte start", a, 1);
        write_byte(8'h03, 1'b0, a);
        write_byte(8'h00, 1'b0, a);
        write_byte(8'h77, 1'b0, a);
        bus_stop();
        chk("R1 write after abort addr", wa_log[base % 8], 13'h0300);
        chk("R1 write after abort data", wd_log[base % 8], 8'h77);
    endtask

    task automatic t_stop_ignore();
        logic a;
        int base = wr_cnt;
        scl_m = 1'b0; w(H);
        write_byte(CW, 1'b0, a);
        chk("R2 byte without start not acked", a, 0);
        chk("R2 no write without start", wr_cnt - base, 0);
        bus_stop();
    endtask

    initial begin
        w(5);
        rst_n = 1'b1;
        w(3);
        t_reset();
        t_select();
        t_write();
        t_write_wrap();
        t_rand_read();
        t_cur_read();
        t_read_wrap();
        t_busy();
        t_abort();
        t_stop_ignore();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule